// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects service requests from eight device lines and raises a single interrupt toward the processor. A device asks for attention by driving its own line high. The controller catches the rising edge of the line and keeps it as a pending request. When no request is being serviced, the most urgent pending request that is not masked raises the interrupt output at once.

When the processor acknowledges, the controller returns a vector number for one cycle. The number is a programmable base times eight plus the index of the winning line, and the processor uses it to index its handler table. The chosen line then stays in service, and every other request waits, until the handler writes an end-of-interrupt command to the control port. Requests that arrive while a line is in service, or that lose a same-cycle race to a more urgent line, stay pending until their turn comes.

A small write-only control port sets the vector base and a per-line mask, and carries the end-of-interrupt command. A masked line still records its request but cannot raise the interrupt until the mask bit is cleared. The reset input is asserted asynchronously and is released inside the block through a two-stage synchroniser.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o and vec_valid_o are low, the mask is all zeros (every line enabled) and the vector base is 0.
- R2: A 0-to-1 change on req_i[k] sets pending bit k on the next clock edge; with nothing in service and line k unmasked, int_o is high in the cycle that follows that edge.
- R3: Among pending unmasked lines, the lowest index wins: line 0 is the most urgent and line 7 the least.
- R4: A cycle with inta_i high while int_o is high selects the winner. On the next cycle vec_valid_o is high for exactly one cycle, int_o is low, and the winner's pending bit is cleared.
- R5: From the acknowledge until an end-of-interrupt write, int_o stays low whatever requests arrive. Those requests are still latched as pending.
- R6: A control write with cfg_addr_i = 2 is the end-of-interrupt command and ends service. If unmasked requests are pending, int_o is high in the cycle after the write. If none are pending, int_o stays low.
- R7: A control write with cfg_addr_i = 1 loads the mask from cfg_wdata_i, where bit k = 1 masks line k. A masked line latches pending but cannot raise int_o or win arbitration. Clearing its mask bit lets its pending request raise int_o in the next cycle.
- R8: A line that is already pending does not queue a second request. Extra rising edges before the acknowledge produce only one service.
- R9: inta_i while int_o is low has no effect: vec_valid_o stays low and no line enters service.
- R10: A control write with cfg_addr_i = 0 loads the 5-bit base from cfg_wdata_i[4:0], and the upper data bits are ignored. vec_o = base*8 + line, that is {base, line[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Device request lines; a rising edge raises a request |
| inta_i | input | 1 | Processor acknowledge |
| cfg_wr_i | input | 1 | Control port write strobe |
| cfg_addr_i | input | 2 | Control port address: 0 = base, 1 = mask, 2 = end of interrupt |
| cfg_wdata_i | input | 8 | Control port write data |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle strobe marking a valid vector |
| vec_o | output | 8 | Vector number, {base, line} |

## Verification
The bench raises two requests in the same cycle and then raises a more urgent one during service. If arbitration were inverted, or the new request were allowed through before the end-of-interrupt write, the order of returned vectors would change or int_o would rise early. It masks a line, serves a less urgent one, and then unmasks the first. A design that ignored the mask, or that dropped a masked request, would return the wrong line or never interrupt again. Repeated edges on a line that is already pending, an acknowledge with no interrupt raised, an end-of-interrupt write while idle, and a base write with its upper bits set round out the tests. Each of these shows up as an extra service, a stray vector strobe, or a wrong vector value.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_MASK = 2'd1,
    CFG_EOI  = 2'd2,
    CFG_RSVD = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] req_q;
  logic [N_LINES-1:0] pend_q, pend_d;

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    logic rise;
    assign rise = req_i[k] & ~req_q[k];
    always_comb begin
      pend_d[k] = pend_q[k];
      if (rise)     pend_d[k] = 1'b1;
      if (clr_i[k]) pend_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] cand_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_LINES-1:0] onehot_o
);
  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned BASE_W  = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [BASE_W-1:0]  base_o,
  output logic [N_LINES-1:0] mask_o,
  output logic               eoi_o
);
  logic [BASE_W-1:0]  base_q, base_d;
  logic [N_LINES-1:0] mask_q, mask_d;
  logic               base_en, mask_en;

  assign base_en = wr_i && (cfg_sel_e'(addr_i) == CFG_BASE);
  assign mask_en = wr_i && (cfg_sel_e'(addr_i) == CFG_MASK);
  assign eoi_o   = wr_i && (cfg_sel_e'(addr_i) == CFG_EOI);

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    if (base_en) base_d = wdata_i[BASE_W-1:0];
    if (mask_en) mask_d = wdata_i[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end

  if (DATA_W > BASE_W && DATA_W > N_LINES) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:((BASE_W > N_LINES) ? BASE_W : N_LINES)];
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned BASE_W  = 5,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_LINES),
  localparam int unsigned VEC_W  = BASE_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               inta_i,
  input  logic               cfg_wr_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  output logic               int_o,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [BASE_W-1:0]  base_w;
  logic [N_LINES-1:0] mask_w, pend_w, clr_w, win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               any_w, eoi_w, take_w;

  irq_cfg_regs #(.N_LINES(N_LINES), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_i(cfg_wr_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .base_o(base_w), .mask_o(mask_w), .eoi_o(eoi_w)
  );

  irq_pend_bank #(.N_LINES(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .req_i(req_i), .clr_i(clr_w), .pend_o(pend_w)
  );

  irq_prio_pick #(.N_LINES(N_LINES)) u_pick (
    .cand_i(pend_w & ~mask_w), .any_o(any_w), .idx_o(win_idx), .onehot_o(win_oh)
  );

  logic             svc_q, svc_d;
  logic             vld_q, vld_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  assign int_o  = any_w & ~svc_q;
  assign take_w = inta_i & int_o;
  assign clr_w  = take_w ? win_oh : '0;

  always_comb begin
    svc_d = svc_q;
    vld_d = take_w;
    vec_d = vec_q;
    if (eoi_w)  svc_d = 1'b0;
    if (take_w) begin
      svc_d = 1'b1;
      vec_d = {base_w, win_idx};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      svc_q <= 1'b0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      svc_q <= svc_d;
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker #(
  parameter int unsigned N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_o,
  input logic               inta_i,
  input logic               vec_valid_o,
  input logic               svc_q,
  input logic               eoi_w,
  input logic [N_LINES-1:0] pend_w,
  input logic [N_LINES-1:0] mask_w
);
  assert_vec_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  assert_int_low_at_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> !int_o);

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> !int_o);

  assert_reassert_after_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_w && svc_q && |(pend_w & ~mask_w)) |=> int_o);

  assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(pend_w & ~mask_w));

  assert_ack_needs_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid_o) |-> $past(inta_i && int_o));
endmodule

bind prio_irq_ctrl prio_irq_checker #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_o(int_o), .inta_i(inta_i),
  .vec_valid_o(vec_valid_o), .svc_q(svc_q), .eoi_w(eoi_w),
  .pend_w(pend_w), .mask_w(mask_w)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] req;
  logic       inta;
  logic       cfg_wr;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       int_o;
  logic       vec_valid;
  logic [7:0] vec;

  int n_chk = 0;
  int n_bad = 0;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .inta_i(inta),
    .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .int_o(int_o), .vec_valid_o(vec_valid), .vec_o(vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic do_ack(input string tag, input int exp_vec);
    inta = 1'b1;
    tick();
    chk({tag, " vec_valid"}, vec_valid, 1);
    chk({tag, " vector"}, vec, exp_vec);
    chk({tag, " int low after ack"}, int_o, 0);
    inta = 1'b0;
    tick();
    chk({tag, " vec_valid one cycle"}, vec_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 int_o after reset", int_o, 0);
    chk("R1 vec_valid after reset", vec_valid, 0);
  endtask

  task automatic t_single();
    req = 8'h08;
    tick();
    chk("R2 int raised by line 3", int_o, 1);
    do_ack("R1 R4 line 3 base 0", 3);
    cfg_write(2'd2, 8'h00);
    chk("R6 int low after eoi, none pending", int_o, 0);
    req = 8'h00;
    tick();
  endtask

  task automatic t_priority();
    cfg_write(2'd0, 8'd5);
    req = 8'h44;
    tick();
    chk("R2 int raised by lines 6,2", int_o, 1);
    do_ack("R3 R10 line 2 wins", 42);
    req = 8'h46;
    tick();
    for (int i = 0; i < 4; i++) begin
      chk("R5 int held off in service", int_o, 0);
      tick();
    end
    cfg_write(2'd2, 8'h00);
    chk("R6 int reasserts after eoi", int_o, 1);
    do_ack("R3 line 1 beats line 6", 41);
    cfg_write(2'd2, 8'h00);
    chk("R6 int reasserts for line 6", int_o, 1);
    do_ack("R3 line 6 last", 46);
    cfg_write(2'd2, 8'h00);
    chk("R6 int low when drained", int_o, 0);
    req = 8'h00;
    tick();
  endtask

  task automatic t_mask();
    cfg_write(2'd1, 8'h10);
    req = 8'h10;
    tick();
    for (int i = 0; i < 3; i++) begin
      chk("R7 masked line silent", int_o, 0);
      tick();
    end
    req = 8'h90;
    tick();
    chk("R7 unmasked line 7 raises int", int_o, 1);
    do_ack("R7 masked line 4 loses to 7", 47);
    cfg_write(2'd2, 8'h00);
    chk("R7 masked pending stays silent", int_o, 0);
    cfg_write(2'd1, 8'h00);
    chk("R7 unmask releases line 4", int_o, 1);
    do_ack("R7 line 4 served", 44);
    cfg_write(2'd2, 8'h00);
    req = 8'h00;
    tick();
  endtask

  task automatic t_nodouble();
    req = 8'h20;
    tick();
    req = 8'h00;
    tick();
    req = 8'h20;
    tick();
    req = 8'h00;
    tick();
    req = 8'h20;
    tick();
    do_ack("R8 line 5 once", 45);
    cfg_write(2'd2, 8'h00);
    chk("R8 no second service", int_o, 0);
    tick();
    chk("R8 held line no retrigger", int_o, 0);
    req = 8'h00;
    tick();
  endtask

  task automatic t_stray();
    inta = 1'b1;
    tick();
    inta = 1'b0;
    chk("R9 stray ack no strobe", vec_valid, 0);
    tick();
    chk("R9 stray ack no strobe later", vec_valid, 0);
    cfg_write(2'd2, 8'h00);
    chk("R9 idle eoi harmless", int_o, 0);
    cfg_write(2'd0, 8'hFF);
    req = 8'h01;
    tick();
    chk("R9 line 0 raises int after stray ack", int_o, 1);
    do_ack("R10 base upper bits dropped", 248);
    cfg_write(2'd2, 8'h00);
    req = 8'h00;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; inta = 1'b0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_single();
    t_priority();
    t_mask();
    t_nodouble();
    t_stray();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule